// File: doc/BRIEF.md
# Banked Scratchpad Conflict Replay Scheduler

This block sits in front of a scratchpad split into 32 banks, each one 4-byte word wide. A warp presents one access per cycle: a word address for each of its 32 lanes and a mask saying which lanes take part. The bank of a lane is its word address modulo the bank count, so two lanes collide when their addresses share the low five bits but differ elsewhere. Lanes that name the very same word are served together as a broadcast and cost nothing extra.

On acceptance the scheduler computes the conflict degree, which is the largest number of distinct words that any single bank is asked for. It then replays the access over exactly that many cycles. Each cycle carries a lane grant mask that touches every bank at most once. The storage arrays behind the scheduler consume one grant mask per cycle. With a stride of two words, for example, 16 banks each see two words and the access takes two passes. With an odd stride every lane lands in its own bank and one pass suffices.

Top module: `bank_replay_sched`

## Requirements
- R1: While reset is applied and after it is released with no request, busy, done, pass_grant and degree are all zero.
- R2: The bank of a lane is bits [4:0] of its word address. Lanes whose addresses differ only above bit 4 fall in the same bank.
- R3: degree, registered on acceptance, equals the largest count of distinct active word addresses falling in one bank. Active lanes with identical addresses count once.
- R4: An accepted request with a nonzero mask produces exactly degree passes, one per cycle, starting in the cycle after acceptance. busy is high in exactly those cycles, and pass_grant is zero whenever busy is low.
- R5: In pass k (counting from 0), each bank grants all lanes holding the k-th distinct address seen in that bank when scanning active lanes from lane 0 upward.
- R6: Grant masks of different passes never overlap, their union equals the accepted mask, and inactive lanes are never granted.
- R7: done is high for one cycle, in the final pass. For an empty mask, degree becomes 0, no pass occurs, busy stays low and done is high in the cycle after acceptance.
- R8: A request presented while busy is high is ignored. It changes neither the grants nor degree, and it starts no replay afterwards.
- R9: degree holds its value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_mask | input | 32 | Active lane mask |
| req_addr | input | 512 | Lane word addresses, lane i at bits [16i+15:16i] |
| busy | output | 1 | High during each replay pass |
| pass_grant | output | 32 | Lanes served in the current pass |
| done | output | 1 | Final pass, or empty access, completes |
| degree | output | 6 | Conflict degree of the last accepted access |

## Verification
The end of a replay and the arrival of a new request can fall in the same cycle. The bench presents a new request with a different mask and addresses during the final pass, and also during the first pass, while busy is still high. It then checks that the current grants and degree are unchanged and that no further pass follows once busy drops. The reference model builds per-bank lists of distinct words independently, and the bench compares the grant mask, busy, done and degree on every cycle against that model.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_REPLAY = 1'b1} phase_e;

  localparam int DEF_LANES  = 32;
  localparam int DEF_BANKS  = 32;
  localparam int DEF_ADDR_W = 16;
endpackage

// File: rtl/brs_rst_sync.sv
module brs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/brs_degree.sv
// Conflict degree: per bank, count lanes that carry a word not seen at a lower active lane.
module brs_degree #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 16,
  parameter int CW     = 6
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES-1:0]        mask,
  output logic [CW-1:0]           degree
);
  localparam int BW = $clog2(BANKS);

  logic [ADDR_W-1:0] a [LANES];
  logic [LANES-1:0]  fresh;
  logic [CW-1:0]     cnt;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign a[g] = addr_flat[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      fresh[i] = mask[i];
      for (int j = 0; j < LANES; j++) begin
        if (j < i && mask[j] && a[j] == a[i]) fresh[i] = 1'b0;
      end
    end
  end

  always_comb begin
    degree = '0;
    cnt    = '0;
    for (int b = 0; b < BANKS; b++) begin
      cnt = '0;
      for (int i = 0; i < LANES; i++) begin
        if (fresh[i] && a[i][BW-1:0] == BW'(b)) cnt = cnt + CW'(1);
      end
      if (cnt > degree) degree = cnt;
    end
  end
endmodule

// File: rtl/brs_picker.sv
// One pass: in each bank, serve every remaining lane sharing the lowest remaining lane's word.
module brs_picker #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 16
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [LANES-1:0]        remain,
  output logic [LANES-1:0]        grant
);
  localparam int BW = $clog2(BANKS);

  logic [ADDR_W-1:0] a [LANES];
  logic [LANES-1:0]  lead;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign a[g] = addr_flat[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lead[i] = remain[i];
      for (int j = 0; j < LANES; j++) begin
        if (j < i && remain[j] && a[j][BW-1:0] == a[i][BW-1:0]) lead[i] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      grant[i] = 1'b0;
      for (int j = 0; j < LANES; j++) begin
        if (j <= i && lead[j] && a[j] == a[i]) grant[i] = remain[i];
      end
    end
  end
endmodule

// File: rtl/bank_replay_sched.sv
module bank_replay_sched
  import brs_pkg::*;
#(
  parameter int LANES  = DEF_LANES,
  parameter int BANKS  = DEF_BANKS,
  parameter int ADDR_W = DEF_ADDR_W,
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [LANES-1:0]        req_mask,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    busy,
  output logic [LANES-1:0]        pass_grant,
  output logic                    done,
  output logic [CW-1:0]           degree
);
  logic                    srst_n;
  phase_e                  state_q, state_d;
  logic [LANES-1:0]        rem_q, rem_d, grant_c, rem_after;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [CW-1:0]           deg_q, deg_c;
  logic                    empty_q, empty_d;
  logic                    load_en;

  brs_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  brs_degree #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W), .CW(CW)) u_deg (
    .addr_flat (req_addr),
    .mask      (req_mask),
    .degree    (deg_c)
  );

  brs_picker #(.LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W)) u_pick (
    .addr_flat (addr_q),
    .remain    (rem_q),
    .grant     (grant_c)
  );

  assign rem_after = rem_q & ~grant_c;
  assign load_en   = (state_q == PH_IDLE) && req_valid;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    empty_d = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (|req_mask) begin
            rem_d   = req_mask;
            state_d = PH_REPLAY;
          end else begin
            empty_d = 1'b1;
          end
        end
      end
      PH_REPLAY: begin
        rem_d = rem_after;
        if (rem_after == '0) state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= PH_IDLE;
      rem_q   <= '0;
      empty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
      deg_q  <= '0;
    end else if (load_en) begin
      addr_q <= req_addr;
      deg_q  <= deg_c;
    end
  end

  assign busy       = (state_q == PH_REPLAY);
  assign pass_grant = busy ? grant_c : '0;
  assign done       = empty_q | (busy && rem_after == '0);
  assign degree     = deg_q;
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int LANES = 32,
  parameter int CW    = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [LANES-1:0] req_mask,
  input logic             busy,
  input logic [LANES-1:0] pass_grant,
  input logic             done,
  input logic [CW-1:0]    degree
);
  logic [LANES-1:0] acc_q, cap_q;
  logic [CW-1:0]    npass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cap_q   <= '0;
      npass_q <= '0;
    end else if (req_valid && !busy) begin
      acc_q   <= '0;
      cap_q   <= req_mask;
      npass_q <= '0;
    end else if (busy) begin
      acc_q   <= acc_q | pass_grant;
      npass_q <= npass_q + CW'(1);
    end
  end

  AST_GRANT_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> ((pass_grant & acc_q) == '0)); // R6
  AST_GRANT_COVER: assert property (@(posedge clk) disable iff (!rst_n) (busy && done) |-> ((acc_q | pass_grant) == cap_q)); // R6
  AST_PASS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (busy && done) |-> (CW'(npass_q + CW'(1)) == degree)); // R4
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (pass_grant == '0)); // R4
  AST_PASS_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (pass_grant != '0)); // R5
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done)); // R7
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && !busy) |-> (degree == '0)); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n) (busy && req_valid) |=> $stable(degree)); // R8
endmodule

bind bank_replay_sched brs_checker #(.LANES(LANES), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_mask   (req_mask),
  .busy       (busy),
  .pass_grant (pass_grant),
  .done       (done),
  .degree     (degree)
);

// File: tb/sim_bank_replay_sched.sv
module sim_bank_replay_sched;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 32;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [L-1:0]  req_mask = '0;
  logic [L*AW-1:0] req_addr = '0;
  logic          busy, done;
  logic [L-1:0]  pass_grant;
  logic [5:0]    degree;

  int n_chk = 0;
  int n_fail = 0;

  logic [AW-1:0] ta [L];
  logic [L-1:0]  tm;
  int            exp_deg;
  logic [L-1:0]  exp_g [L];
  int            bq [L][$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_replay_sched u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mask(req_mask),
    .req_addr(req_addr), .busy(busy), .pass_grant(pass_grant), .done(done),
    .degree(degree)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Reference: per bank, ordered list of distinct words in ascending lane order.
  task automatic build_model();
    for (int b = 0; b < L; b++) bq[b].delete();
    for (int i = 0; i < L; i++) begin
      if (tm[i]) begin
        int bk = int'(ta[i]) % 32;
        bit seen = 0;
        foreach (bq[bk][k]) if (bq[bk][k] == int'(ta[i])) seen = 1;
        if (!seen) bq[bk].push_back(int'(ta[i]));
      end
    end
    exp_deg = 0;
    for (int b = 0; b < L; b++) if (bq[b].size() > exp_deg) exp_deg = bq[b].size();
    for (int k = 0; k < L; k++) begin
      exp_g[k] = '0;
      for (int i = 0; i < L; i++) begin
        int bk = int'(ta[i]) % 32;
        if (tm[i] && k < bq[bk].size() && bq[bk][k] == int'(ta[i])) exp_g[k][i] = 1'b1;
      end
    end
  endtask

  task automatic check_idle(input string tag);
    chk(tag, "busy", 64'(busy), 64'(0));
    chk(tag, "done", 64'(done), 64'(0));
    chk(tag, "grant", 64'(pass_grant), 64'(0));
  endtask

  // intrude: pass index during which a foreign request is presented (-1 none)
  task automatic run_req(input string tag, input int intrude);
    build_model();
    @(negedge clk);
    req_valid = 1'b1;
    req_mask  = tm;
    for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = ta[i];
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_deg == 0) begin
      chk(tag, "empty busy", 64'(busy), 64'(0));
      chk(tag, "empty done", 64'(done), 64'(1));
      chk(tag, "empty grant", 64'(pass_grant), 64'(0));
      chk(tag, "empty degree", 64'(degree), 64'(0));
      @(negedge clk);
    end else begin
      for (int k = 0; k < exp_deg; k++) begin
        chk(tag, "busy", 64'(busy), 64'(1));
        chk(tag, "grant", 64'(pass_grant), 64'(exp_g[k]));
        chk(tag, "done", 64'(done), 64'(k == exp_deg - 1));
        chk(tag, "degree", 64'(degree), 64'(exp_deg));
        if (k == intrude) begin
          req_valid = 1'b1;
          req_mask  = '1;
          for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = AW'(i * 64 + 7);
        end
        @(negedge clk);
        req_valid = 1'b0;
      end
    end
    check_idle(tag);
    chk(tag, "degree held", 64'(degree), 64'(exp_deg));
  endtask

  task automatic fill_stride(input int base, input int s, input logic [L-1:0] m);
    for (int i = 0; i < L; i++) ta[i] = AW'(base + i * s);
    tm = m;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 in reset");
    chk("R1", "degree in reset", 64'(degree), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");
    chk("R1", "degree after reset", 64'(degree), 64'(0));

    fill_stride(0, 1, '1);  run_req("R3 stride1 one pass", -1);
    fill_stride(0, 2, '1);  run_req("R3 stride2 two-way", -1);
    fill_stride(5, 3, '1);  run_req("R3 odd stride conflict free", -1);
    fill_stride(0, 16, '1); run_req("R4 stride16 sixteen passes", -1);
    fill_stride(3, 32, '1); run_req("R2 high bits only same bank", -1);
    fill_stride(9, 0, '1);  run_req("R3 broadcast single word", -1);

    fill_stride(0, 1, '0);
    ta[0] = 16'd37; ta[1] = 16'd5; ta[2] = 16'd37; ta[3] = 16'd69;
    tm = 32'h0000_000F;
    run_req("R5 first appearance order", -1);

    fill_stride(0, 2, 32'h0000_FFFF);
    ta[20] = 16'd64;
    run_req("R6 inactive lanes excluded", -1);

    fill_stride(0, 1, 32'hA5A5_0F0F);
    ta[1] = 16'd33; ta[8] = 16'd33; ta[9] = 16'd65;
    run_req("R6 partial mask mixed", -1);

    fill_stride(0, 2, '0);  run_req("R7 empty mask", -1);

    fill_stride(0, 4, '1);  run_req("R8 request during first pass", 0);
    fill_stride(1, 2, '1);  run_req("R8 request during final pass", 1);
    fill_stride(0, 8, '1);  run_req("R9 back to back", -1);
    repeat (3) @(negedge clk);
    chk("R9", "degree held idle", 64'(degree), 64'(8));
    check_idle("R9 quiet");

    finish_run();
  end
endmodule